// File: doc/BRIEF.md
# Pipelined Sine Generator

This block turns a phase angle into its sine. The angle is a 16-bit two's-complement word that spans the whole circle, and the result is a 16-bit signed amplitude in which full scale stands for 1.0. The block works as a rotation-mode shift-add engine. The radius is fixed at one, the y coordinate starts at zero, and only the final y coordinate is kept.

Each result passes through a fixed number of pipeline registers, so no clock cycle holds a long chain of sign-steered additions. The block can take a new angle on every clock cycle.

The two leading angle bits pick a quadrant, and the angle is folded into the first quadrant. The next three bits choose one of eight precomputed starting vectors. These vectors are scaled down ahead of time to cancel the gain of the later stages, and they replace the coarse early micro-rotations. Twelve shift-add stages, using shifts 4 through 15, then refine the vector. A final stage rounds the result, clamps it and restores the sign.

Top module: `sineCordicTop`

## Requirements
- R1: `validOut` rises exactly 14 clock cycles after the cycle in which `validIn` is sampled high. One result appears for each accepted angle, and angles may arrive on every cycle.
- R2: A synchronous `rst` clears every in-flight valid flag. `validOut` is low in the cycle that follows any clock edge at which `rst` is high, and no angle accepted before the reset ever produces a result.
- R3: The angle code spans the full circle in 65536 steps, so 0x4000 is +90 degrees, 0x8000 is 180 degrees and 0xC000 is 270 degrees. Each result is within 16 LSB of round(32767 * sin(angle)).
- R4: An angle with bit 15 clear yields a result of 0 or more. An angle with bit 15 set yields a result of 0 or less.
- R5: The result stays within -32767 to +32767 and never equals -32768. Angles 0x4000 and 0xC000 give results within 16 LSB of +32767 and -32767.
- R6: Accuracy (R3) also holds at and next to every starting-vector segment edge, which lie at multiples of 0x800 in each quadrant, and at the quadrant edges themselves.
- R7: `sineOut` keeps its last value during every cycle in which `validOut` is low.
- R8: `angleIn` is ignored while `validIn` is low. No result is produced, and `sineOut` does not change.
- R9: Gaps in the input valid stream are reproduced exactly at the output. No result appears that was not requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the valid pipeline |
| validIn | input | 1 | High when `angleIn` carries an angle to convert |
| angleIn | input | 16 | Phase angle, two's complement, full circle = 65536 codes |
| validOut | output | 1 | High for one cycle per result |
| sineOut | output | 16 | Signed sine result, full scale = 32767 |

## Verification
Two events can share a cycle here: a new angle is accepted while an older result leaves the last stage, and a reset can land while results are still in flight. The bench provokes the first with a continuous burst of several hundred angles, far longer than the 14-cycle depth. It judges the result by popping each expected value in order and checking that value's arrival cycle. It provokes the second by raising reset in the middle of a burst, which flushes the expectation queue. After that, any result that appears counts as an unrequested output, and any change of `sineOut` while `validOut` is low counts as a hold error.

// File: rtl/sineCordicPkg.sv
package sineCordicPkg;

  typedef struct packed {
    logic seedEn;   // load folded angle and start vector
    logic outEn;    // load rounded, signed result
  } sineStrobeT;

  localparam real PI_R = 3.14159265358979323846;

  // Product of the stretch factors of the shift-add stages actually used.
  function automatic real stageGain(int firstIter, int lastIter);
    real g;
    g = 1.0;
    for (int i = firstIter; i <= lastIter; i++) g = g * $sqrt(1.0 + 2.0 ** (-2 * i));
    return g;
  endfunction

  // atan(2^-iter) expressed in units of one circle / 2^circleBits.
  function automatic int atanUnits(int iter, int circleBits);
    real v;
    v = $atan(2.0 ** (-iter)) * (2.0 ** circleBits) / (2.0 * PI_R);
    return $rtoi(v + 0.5);
  endfunction

  // Start vector coordinate at the centre of segment idx, divided by the stage gain.
  function automatic int seedCoord(bit wantSin, int idx, int angW, int seedBits,
                                   int firstIter, int lastIter, int one);
    real step;
    real ang;
    real v;
    step = 2.0 ** (angW - 2 - seedBits);
    ang  = (idx * step + step / 2.0) * 2.0 * PI_R / (2.0 ** angW);
    v    = wantSin ? $sin(ang) : $cos(ang);
    v    = v * one / stageGain(firstIter, lastIter);
    return $rtoi(v + 0.5);
  endfunction

endpackage

// File: rtl/sineCtrl.sv
module sineCtrl
  import sineCordicPkg::*;
#(
  parameter int NITER = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             validIn,
  output sineStrobeT       strb,
  output logic [NITER-1:0] iterEn,
  output logic             validOut
);

  // vld[0]: seed register full; vld[k+1]: after stage k; vld[NITER+1]: result
  logic [NITER+1:0] vld;

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else     vld <= {vld[NITER:0], validIn};
  end

  always_comb begin
    strb.seedEn = validIn;
    strb.outEn  = vld[NITER];
  end

  assign iterEn   = vld[NITER-1:0];
  assign validOut = vld[NITER+1];

  // Occupancy count, observed only by the checks below
  localparam int CW = $clog2(NITER + 3) + 1;
  logic [CW-1:0] inFlight;

  always_ff @(posedge clk) begin
    if (rst) inFlight <= '0;
    else     inFlight <= inFlight + CW'(validIn) - CW'(validOut);
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !validOut); // R2
  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (rst)
    validOut |-> inFlight != '0); // R9
  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (rst)
    inFlight <= CW'(NITER + 2)); // R1

endmodule

// File: rtl/sineDatapath.sv
module sineDatapath
  import sineCordicPkg::*;
#(
  parameter int ANG_W      = 16,
  parameter int OUT_W      = 16,
  parameter int GUARD      = 2,
  parameter int ZF         = 4,
  parameter int SEED_BITS  = 3,
  parameter int FIRST_ITER = 4,
  parameter int LAST_ITER  = 15
) (
  input  logic                       clk,
  input  logic                       rst,
  input  sineStrobeT                 strb,
  input  logic [LAST_ITER-FIRST_ITER:0] iterEn,
  input  logic [ANG_W-1:0]           angleIn,
  output logic signed [OUT_W-1:0]    sineOut
);

  localparam int NITER = LAST_ITER - FIRST_ITER + 1;
  localparam int W     = OUT_W + GUARD + 1;     // guard bits plus one headroom bit
  localparam int ZW    = ANG_W + ZF;            // residual angle with fraction bits
  localparam int AW    = ANG_W - 1;             // folded angle, 0 .. quarter circle
  localparam int SEEDS = 1 << SEED_BITS;
  localparam int STEP  = 1 << (ANG_W - 2 - SEED_BITS);
  localparam int OMAX  = (1 << (OUT_W - 1)) - 1;
  localparam int ONE   = OMAX << GUARD;

  localparam logic signed [ZW-1:0]    Z_LIM    = ZW'((STEP / 2) << ZF);
  localparam logic signed [ZW-1:0]    Z_BND    = ZW'(2 * atanUnits(LAST_ITER - 1, ANG_W + ZF) + NITER);
  localparam logic signed [W-1:0]     Y_HI     = W'(ONE + (1 << (GUARD + 4)));
  localparam logic signed [W-1:0]     Y_LO     = -W'(1 << (GUARD + 4));
  localparam logic signed [W-1:0]     RND_HALF = W'(1 << (GUARD - 1));
  localparam logic signed [OUT_W:0]   SAT_HI   = (OUT_W + 1)'(OMAX);
  localparam logic signed [OUT_W-1:0] MAG_MAX  = OUT_W'(OMAX);

  // ---------------- quadrant fold and segment select ----------------
  logic [1:0]                quad;
  logic [AW-1:0]             resid;
  logic [AW-1:0]             folded;
  logic [SEED_BITS-1:0]      segIdx;
  logic [AW-1:0]             segMid;
  logic signed [AW:0]        dAng;
  logic signed [ZW-1:0]      zSeed;

  always_comb begin
    quad   = angleIn[ANG_W-1 -: 2];
    resid  = {1'b0, angleIn[ANG_W-3:0]};
    folded = quad[0] ? (AW'(1 << (ANG_W - 2)) - resid) : resid;
    segIdx = folded[AW-1] ? {SEED_BITS{1'b1}} : folded[AW-2 -: SEED_BITS];
    segMid = AW'(segIdx) * AW'(STEP) + AW'(STEP / 2);
    dAng   = $signed({1'b0, folded}) - $signed({1'b0, segMid});
    zSeed  = ZW'(dAng) <<< ZF;
  end

  // ---------------- prescaled start vectors ----------------
  logic signed [W-1:0] seedXRom [SEEDS];
  logic signed [W-1:0] seedYRom [SEEDS];

  for (genvar g = 0; g < SEEDS; g++) begin : gSeed
    localparam int SX = seedCoord(1'b0, g, ANG_W, SEED_BITS, FIRST_ITER, LAST_ITER, ONE);
    localparam int SY = seedCoord(1'b1, g, ANG_W, SEED_BITS, FIRST_ITER, LAST_ITER, ONE);
    assign seedXRom[g] = W'(SX);
    assign seedYRom[g] = W'(SY);
  end

  // ---------------- pipeline state ----------------
  logic signed [W-1:0]  xP   [0:NITER-1];
  logic signed [W-1:0]  yP   [0:NITER];
  logic signed [ZW-1:0] zP   [0:NITER-1];
  logic                 negP [0:NITER];

  always_ff @(posedge clk) begin
    if (strb.seedEn) begin
      xP[0]   <= seedXRom[segIdx];
      yP[0]   <= seedYRom[segIdx];
      zP[0]   <= zSeed;
      negP[0] <= quad[1];
    end
  end

  for (genvar k = 0; k < NITER; k++) begin : gStage
    localparam int                   SH    = FIRST_ITER + k;
    localparam logic signed [ZW-1:0] ZSTEP = ZW'(atanUnits(FIRST_ITER + k, ANG_W + ZF));
    logic ccw;
    assign ccw = !zP[k][ZW-1];

    always_ff @(posedge clk) begin
      if (iterEn[k]) begin
        yP[k+1]   <= ccw ? yP[k] + (xP[k] >>> SH) : yP[k] - (xP[k] >>> SH);
        negP[k+1] <= negP[k];
      end
    end

    // the last stage needs neither x nor the residual angle afterwards
    if (k < NITER - 1) begin : gXZ
      always_ff @(posedge clk) begin
        if (iterEn[k]) begin
          xP[k+1] <= ccw ? xP[k] - (yP[k] >>> SH) : xP[k] + (yP[k] >>> SH);
          zP[k+1] <= ccw ? zP[k] - ZSTEP : zP[k] + ZSTEP;
        end
      end
    end
  end

  // ---------------- round, clamp, restore sign ----------------
  logic signed [W-1:0]     yRnd;
  logic signed [OUT_W:0]   yShr;
  logic signed [OUT_W-1:0] mag;

  always_comb begin
    yRnd = yP[NITER] + RND_HALF;
    yShr = $signed(yRnd[W-1:GUARD]);
    if (yShr > SAT_HI)     mag = MAG_MAX;
    else if (yShr[OUT_W])  mag = '0;
    else                   mag = yShr[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (strb.outEn) sineOut <= negP[NITER] ? -mag : mag;
  end

  AST_SEED_WINDOW: assert property (@(posedge clk) disable iff (rst)
    strb.seedEn |=> (zP[0] >= -Z_LIM && zP[0] <= Z_LIM)); // R6
  AST_RESIDUE_CONVERGES: assert property (@(posedge clk) disable iff (rst)
    iterEn[NITER-2] |=> (zP[NITER-1] >= -Z_BND && zP[NITER-1] <= Z_BND)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    iterEn[NITER-1] |=> (yP[NITER] <= Y_HI && yP[NITER] >= Y_LO)); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strb.outEn |=> $stable(sineOut)); // R7

endmodule

// File: rtl/sineCordicTop.sv
module sineCordicTop
  import sineCordicPkg::*;
#(
  parameter int ANG_W      = 16,
  parameter int OUT_W      = 16,
  parameter int GUARD      = 2,
  parameter int ZF         = 4,
  parameter int SEED_BITS  = 3,
  parameter int FIRST_ITER = 4,
  parameter int LAST_ITER  = 15
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    validIn,
  input  logic [ANG_W-1:0]        angleIn,
  output logic                    validOut,
  output logic signed [OUT_W-1:0] sineOut
);

  localparam int NITER = LAST_ITER - FIRST_ITER + 1;

  sineStrobeT       strb;
  logic [NITER-1:0] iterEn;

  sineCtrl #(.NITER(NITER)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .validIn  (validIn),
    .strb     (strb),
    .iterEn   (iterEn),
    .validOut (validOut)
  );

  sineDatapath #(
    .ANG_W      (ANG_W),
    .OUT_W      (OUT_W),
    .GUARD      (GUARD),
    .ZF         (ZF),
    .SEED_BITS  (SEED_BITS),
    .FIRST_ITER (FIRST_ITER),
    .LAST_ITER  (LAST_ITER)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .iterEn  (iterEn),
    .angleIn (angleIn),
    .sineOut (sineOut)
  );

endmodule

// File: tb/sineCordicTop_tb.sv
`timescale 1ns/1ps
module sineCordicTop_tb;

  localparam int LAT = 14;
  localparam int TOL = 16;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               validIn = 1'b0;
  logic [15:0]        angleIn = '0;
  logic               validOut;
  logic signed [15:0] sineOut;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int qExp[$];
  int qIssue[$];
  int qAng[$];
  logic signed [15:0] lastOut;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  sineCordicTop u_dut (
    .clk      (clk),
    .rst      (rst),
    .validIn  (validIn),
    .angleIn  (angleIn),
    .validOut (validOut),
    .sineOut  (sineOut)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int refSin(int ang);
    real th;
    real v;
    th = ang * 2.0 * 3.14159265358979323846 / 65536.0;
    v  = 32767.0 * $sin(th);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  task automatic send(int ang);
    @(negedge clk);
    validIn = 1'b1;
    angleIn = ang[15:0];
    qExp.push_back(refSin(ang & 16'hFFFF));
    qIssue.push_back(cyc);
    qAng.push_back(ang & 16'hFFFF);
  endtask

  // R8: idle cycles carry random garbage on angleIn
  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      validIn = 1'b0;
      angleIn = 16'($urandom);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst) begin
      lastOut = sineOut;
    end else if (validOut) begin
      if (qExp.size() == 0) begin
        check(1'b0, "R9 unrequested output", int'(sineOut), 0);
      end else begin
        int e;
        int iss;
        int a;
        int d;
        e   = qExp.pop_front();
        iss = qIssue.pop_front();
        a   = qAng.pop_front();
        d   = int'(sineOut) - e;
        check(d <= TOL && d >= -TOL, $sformatf("R3 angle=0x%04h", a), int'(sineOut), e);
        check(cyc - iss == LAT, "R1 latency", cyc - iss, LAT);
        if (a[15]) check(sineOut <= 0, "R4 sign", int'(sineOut), e);
        else       check(sineOut >= 0, "R4 sign", int'(sineOut), e);
        check(sineOut != -16'sd32768, "R5 range", int'(sineOut), -32767);
      end
      lastOut = sineOut;
    end else begin
      check(sineOut == lastOut, "R7 hold", int'(sineOut), int'(lastOut));
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R1 watchdog expired", cyc, 0);
      finishRun();
    end
  end

  initial begin
    // reset state
    repeat (3) begin
      @(negedge clk);
      check(validOut == 1'b0, "R2 reset state", int'(validOut), 0);
    end
    @(negedge clk);
    rst = 1'b0;
    idle(20);

    // R5 and R4: cardinal points, with bubbles between them (R9)
    send(16'h0000); idle(1);
    send(16'h4000); idle(2);
    send(16'h8000); idle(1);
    send(16'hC000); idle(3);
    send(16'h2000); send(16'h6000); idle(1);
    send(16'hA000); send(16'hE000); idle(1);
    send(16'h0001); send(16'hFFFF); send(16'h3FFF); send(16'h4001);
    send(16'h7FFF); send(16'h8001); send(16'hBFFF); send(16'hC001);
    idle(LAT + 4);

    // R6: segment edges in every quadrant
    for (int q = 0; q < 4; q++) begin
      for (int k = 0; k <= 8; k++) begin
        send(q * 16'h4000 + k * 16'h800);
        send(q * 16'h4000 + k * 16'h800 + 1);
        send(q * 16'h4000 + k * 16'h800 - 1);
      end
    end
    idle(LAT + 4);

    // R8: a long stretch of garbage with validIn low, pipeline empty
    idle(40);

    // R1: a back-to-back burst, entries overlapping exits
    for (int i = 0; i < 300; i++) send(int'($urandom) & 16'hFFFF);
    idle(LAT + 4);

    // R9: irregular valid pattern
    for (int i = 0; i < 200; i++) begin
      if (($urandom % 3) == 0) idle(1 + ($urandom % 4));
      send(int'($urandom) & 16'hFFFF);
    end
    idle(LAT + 4);

    // R2: reset lands while results are in flight
    for (int i = 0; i < 8; i++) send(16'h1000 + i * 16'h123);
    @(negedge clk);
    validIn = 1'b0;
    rst = 1'b1;
    qExp.delete();
    qIssue.delete();
    qAng.delete();
    repeat (3) begin
      @(negedge clk);
      check(validOut == 1'b0, "R2 flush", int'(validOut), 0);
    end
    rst = 1'b0;
    idle(LAT + 6);   // the monitor flags any stale result (R9) or output change (R7)

    // sweep across the whole circle
    for (int a = 0; a < 65536; a += 97) send(a);
    idle(LAT + 4);

    while (qExp.size() != 0) @(negedge clk);
    idle(4);
    done = 1;
    finishRun();
  end

endmodule